// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block turns a byte stream from the MAC side into the nibble-wide transmit side of a Media Independent Interface. Bytes arrive with valid, last and ready handshake signals. For each frame the block sends the preamble and start-of-frame delimiter, then every payload byte as two nibbles, then the 32-bit frame check sequence. It holds the transmit enable high from the first preamble nibble to the last check-sequence nibble. Every output is registered on the rising edge of the transmit clock that the PHY supplies (25 MHz at 100 Mbps, 2.5 MHz at 10 Mbps).

The collision input from the PHY is asynchronous. A chain of flip-flops clocked by the transmit clock brings it into that domain. A collision seen during a frame replaces the rest of the frame with a jam pattern and ends the frame as aborted. If the byte source has no byte ready when one is due, the block ends the frame and reports an underrun. After either event, the block accepts and throws away the rest of the frame's bytes, so the next frame starts clean. Padding, backoff, retry and deferral belong to the MAC that drives this block.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is held and after it is released, `mii_txen`, `mii_txd`, `s_ready` and the three status pulses are all 0.
- R2: When `s_valid` is high in the idle state, `mii_txen` rises on the next clock edge and the first nibble is 0x5. The delimiter and preamble together are fifteen 0x5 nibbles followed by one 0xD nibble.
- R3: Each payload byte goes out as bits [3:0] and then bits [7:4]. Within a nibble, `mii_txd[0]` carries the least significant bit.
- R4: `s_ready` is high only in the cycle before a low nibble is due. A source that never stalls gets an unbroken enable window of exactly 16 + 2·N + 8 nibbles for N payload bytes, and the enable rises once per frame.
- R5: The check sequence is the Ethernet CRC-32 of the payload: reflected polynomial 0xEDB88320, start value all ones, result inverted. It is sent least significant nibble first. For the nine ASCII bytes "123456789" the nibbles are 6,2,9,3,4,F,B,C.
- R6: `mii_txen` falls on the edge after the last check-sequence nibble. `frame_done` pulses for one cycle in that same cycle.
- R7: Whenever `mii_txen` is low, `mii_txd` is 0.
- R8: `col_async` passes through `SYNC_STAGES` flip-flops (default 2). A collision set up before edge k during a frame lets normal nibbles go out at edges k and k+1. The block then sends `JAM_NIBBLES` (default 8) nibbles of `JAM_NIB` (default 0x5), drops `mii_txen`, and pulses `frame_abort` in the cycle the enable falls.
- R9: A collision while the block is idle has no effect: no enable and no `frame_abort`.
- R10: If `s_valid` is low when a low nibble is due, `mii_txen` falls on that edge and `tx_underrun` pulses in the same cycle.
- R11: After an abort or an underrun, `s_ready` stays high with `mii_txen` low. Bytes are discarded until the beat marked `s_last`, and the next frame then goes out intact.
- R12: At most one of `frame_done`, `frame_abort` and `tx_underrun` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_data | input | 8 | Frame byte from the MAC side |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | This byte is the last byte of the frame |
| s_ready | output | 1 | The block takes the byte at this edge |
| col_async | input | 1 | Collision signal from the PHY, asynchronous |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |
| frame_done | output | 1 | One-cycle pulse when a frame completes normally |
| frame_abort | output | 1 | One-cycle pulse when a frame ends after the jam |
| tx_underrun | output | 1 | One-cycle pulse when a frame ends because a byte was missing |

## Verification
The checks take three things for granted. `s_valid` stays low between frames until the block is idle. `s_last` marks exactly one byte per frame. `col_async` is only ever raised as a level that lasts several clock cycles. The stimulus changes every input at the falling clock edge. It always ends a frame with a last-marked beat, including after an abort or underrun. It raises the collision for three cycles at a time, during the preamble, during the payload and while idle. Stalls are placed so that an underrun happens at a known byte index.

// File: rtl/mii_tx_pkg.sv
`timescale 1ns/1ps
package mii_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_LO,
      ST_HI,
      ST_FCS,
      ST_JAM,
      ST_DRAIN
   } tx_state_e;

   localparam int          PRE_LEN   = 16;
   localparam int          FCS_NIBS  = 8;
   localparam logic [3:0]  PRE_NIB   = 4'h5;
   localparam logic [3:0]  SFD_NIB   = 4'hD;
   localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

   // One byte of reflected CRC-32, bit 0 of the byte first.
   function automatic logic [31:0] crc_step_byte(input logic [31:0] c,
                                                 input logic [7:0]  b);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/mii_col_sync.sv
`timescale 1ns/1ps
module mii_col_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mii_col_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= g_stage[g-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/mii_tx_crc.sv
`timescale 1ns/1ps
module mii_tx_crc
   import mii_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        take,
   input  logic [7:0]  byte_in,
   output logic [31:0] fcs
);

   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= CRC_SEED;
      else if (restart) crc_q <= CRC_SEED;
      else if (take)    crc_q <= crc_step_byte(crc_q, byte_in);
   end

   assign fcs = ~crc_q;

endmodule

// File: rtl/mii_tx_framer.sv
`timescale 1ns/1ps
module mii_tx_framer
   import mii_tx_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         JAM_NIBBLES = 8,
   parameter logic [3:0] JAM_NIB     = 4'h5
) (
   input  logic       tx_clk,
   input  logic       rst_n,
   input  logic [7:0] s_data,
   input  logic       s_valid,
   input  logic       s_last,
   output logic       s_ready,
   input  logic       col_async,
   output logic [3:0] mii_txd,
   output logic       mii_txen,
   output logic       frame_done,
   output logic       frame_abort,
   output logic       tx_underrun
);

   localparam int CNT_MAX = (JAM_NIBBLES > PRE_LEN) ? JAM_NIBBLES : PRE_LEN;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (JAM_NIBBLES < 1 || JAM_NIBBLES > 64) begin : g_bad_jam
      $error("mii_tx_framer: JAM_NIBBLES out of range");
   end

   tx_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       hold_q;
   logic             last_q;
   logic             seen_last_q;
   logic [3:0]       txd_q;
   logic             txen_q;
   logic             done_q, abort_q, unr_q;
   logic             col_s;
   logic             in_frame;
   logic             col_hit;
   logic             take;
   logic [31:0]      fcs_w;

   mii_col_sync #(.STAGES(SYNC_STAGES)) col_sync_i (
      .clk   (tx_clk),
      .rst_n (rst_n),
      .d     (col_async),
      .q     (col_s)
   );

   assign in_frame = (state_q == ST_PRE) || (state_q == ST_LO) ||
                     (state_q == ST_HI)  || (state_q == ST_FCS);
   assign col_hit  = col_s && in_frame;
   assign s_ready  = ((state_q == ST_LO) && !col_s) || (state_q == ST_DRAIN);
   assign take     = (state_q == ST_LO) && !col_s && s_valid;

   mii_tx_crc crc_i (
      .clk     (tx_clk),
      .rst_n   (rst_n),
      .restart (state_q == ST_IDLE),
      .take    (take),
      .byte_in (s_data),
      .fcs     (fcs_w)
   );

   always_ff @(posedge tx_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         hold_q      <= '0;
         last_q      <= 1'b0;
         seen_last_q <= 1'b0;
         txd_q       <= '0;
         txen_q      <= 1'b0;
         done_q      <= 1'b0;
         abort_q     <= 1'b0;
         unr_q       <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         unr_q   <= 1'b0;
         if (col_hit && !(state_q == ST_FCS && cnt_q == CNT_W'(FCS_NIBS))) begin
            state_q <= ST_JAM;
            txd_q   <= JAM_NIB;
            cnt_q   <= CNT_W'(1);
         end else begin
            case (state_q)
               ST_IDLE: begin
                  txen_q      <= 1'b0;
                  txd_q       <= '0;
                  seen_last_q <= 1'b0;
                  if (s_valid) begin
                     state_q <= ST_PRE;
                     txen_q  <= 1'b1;
                     txd_q   <= PRE_NIB;
                     cnt_q   <= CNT_W'(1);
                  end
               end
               ST_PRE: begin
                  if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
                     txd_q   <= SFD_NIB;
                     state_q <= ST_LO;
                  end else begin
                     txd_q <= PRE_NIB;
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_LO: begin
                  if (s_valid) begin
                     txd_q       <= s_data[3:0];
                     hold_q      <= s_data[7:4];
                     last_q      <= s_last;
                     seen_last_q <= s_last;
                     state_q     <= ST_HI;
                  end else begin
                     txen_q  <= 1'b0;
                     txd_q   <= '0;
                     unr_q   <= 1'b1;
                     state_q <= ST_DRAIN;
                  end
               end
               ST_HI: begin
                  txd_q   <= hold_q;
                  cnt_q   <= '0;
                  state_q <= last_q ? ST_FCS : ST_LO;
               end
               ST_FCS: begin
                  if (cnt_q == CNT_W'(FCS_NIBS)) begin
                     txen_q  <= 1'b0;
                     txd_q   <= '0;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     txd_q <= fcs_w[{cnt_q[2:0], 2'b00} +: 4];
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_JAM: begin
                  if (cnt_q == CNT_W'(JAM_NIBBLES)) begin
                     txen_q  <= 1'b0;
                     txd_q   <= '0;
                     abort_q <= 1'b1;
                     state_q <= seen_last_q ? ST_IDLE : ST_DRAIN;
                  end else begin
                     txd_q <= JAM_NIB;
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DRAIN: begin
                  txen_q <= 1'b0;
                  txd_q  <= '0;
                  if (s_valid && s_last) state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign mii_txd     = txd_q;
   assign mii_txen    = txen_q;
   assign frame_done  = done_q;
   assign frame_abort = abort_q;
   assign tx_underrun = unr_q;

endmodule

// File: rtl/mii_tx_framer_chk.sv
`timescale 1ns/1ps
module mii_tx_framer_chk #(
   parameter logic [3:0] JAM_NIB = 4'h5
) (
   input logic       tx_clk,
   input logic       rst_n,
   input logic [3:0] mii_txd,
   input logic       mii_txen,
   input logic       frame_done,
   input logic       frame_abort,
   input logic       tx_underrun
);

   // R2
   pre_start_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
      $rose(mii_txen) |-> mii_txd == 4'h5);

   // R7
   idle_zero_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
      !mii_txen |-> mii_txd == 4'h0);

   // R6
   done_edge_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
      frame_done |-> $fell(mii_txen));

   // R8
   abort_jam_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
      frame_abort |-> $fell(mii_txen) && $past(mii_txd) == JAM_NIB);

   // R10
   underrun_edge_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
      tx_underrun |-> $fell(mii_txen));

   // R12
   one_flag_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
      $onehot0({frame_done, frame_abort, tx_underrun}));

endmodule

bind mii_tx_framer mii_tx_framer_chk #(.JAM_NIB(JAM_NIB)) chk_i (
   .tx_clk      (tx_clk),
   .rst_n       (rst_n),
   .mii_txd     (mii_txd),
   .mii_txen    (mii_txen),
   .frame_done  (frame_done),
   .frame_abort (frame_abort),
   .tx_underrun (tx_underrun)
);

// File: tb/mii_tx_framer_tb.sv
`timescale 1ns/1ps
module mii_tx_framer_tb_top;

   localparam int NV = 4;
   // length, first byte, byte increment
   localparam int VEC [NV][3] = '{
      '{60,   8'h11, 3},
      '{1,    8'hA5, 0},
      '{1514, 8'h00, 1},
      '{46,   8'hF0, 7}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] s_data = '0;
   logic       s_valid = 1'b0;
   logic       s_last = 1'b0;
   logic       s_ready;
   logic       col_async = 1'b0;
   logic [3:0] mii_txd;
   logic       mii_txen;
   logic       frame_done, frame_abort, tx_underrun;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] pbuf [0:2047];
   logic [3:0] nib  [0:4095];
   int nib_cnt = 0;
   int n_done = 0, n_abort = 0, n_unr = 0, n_rise = 0;
   logic prev_en = 1'b0;

   always #2.5 clk = ~clk;

   mii_tx_framer dut_i (
      .tx_clk      (clk),
      .rst_n       (rst_n),
      .s_data      (s_data),
      .s_valid     (s_valid),
      .s_last      (s_last),
      .s_ready     (s_ready),
      .col_async   (col_async),
      .mii_txd     (mii_txd),
      .mii_txen    (mii_txen),
      .frame_done  (frame_done),
      .frame_abort (frame_abort),
      .tx_underrun (tx_underrun)
   );

   always @(posedge clk) begin
      #1;
      if (mii_txen && nib_cnt < 4096) begin
         nib[nib_cnt] = mii_txd;
         nib_cnt++;
      end
      if (mii_txen && !prev_en) n_rise++;
      prev_en = mii_txen;
      if (frame_done)  n_done++;
      if (frame_abort) n_abort++;
      if (tx_underrun) n_unr++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic mon_clear();
      @(negedge clk);
      nib_cnt = 0; n_done = 0; n_abort = 0; n_unr = 0; n_rise = 0;
   endtask

   task automatic fill(input int n, input int seed, input int step);
      for (int i = 0; i < n; i++) pbuf[i] = 8'(seed + step * i);
   endtask

   function automatic logic [31:0] ref_fcs(input int n);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++)
         for (int b = 0; b < 8; b++)
            c = ((c[0] ^ pbuf[i][b]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      return ~c;
   endfunction

   task automatic send_frame(input int n, input int stall_at);
      int idx = 0;
      int st = 0;
      bit r;
      while (idx < n) begin
         @(negedge clk);
         if (idx == stall_at && st < 4) begin
            s_valid = 1'b0; st++;
         end else begin
            s_valid = 1'b1; s_data = pbuf[idx]; s_last = (idx == n - 1);
         end
         #1 r = s_ready && s_valid;
         @(posedge clk);
         if (r) idx++;
      end
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic check_frame(input int n, input string tag);
      int bad_pre = 0, bad_dat = 0, bad_fcs = 0;
      logic [31:0] f;
      f = ref_fcs(n);
      repeat (16) @(negedge clk);
      // R4 window length and single rise
      chk(nib_cnt == 16 + 2 * n + 8, {"R4 length ", tag}, nib_cnt, 16 + 2 * n + 8);
      chk(n_rise == 1, {"R4 rises ", tag}, n_rise, 1);
      // R2 preamble and delimiter
      for (int i = 0; i < 15; i++) if (nib[i] !== 4'h5) bad_pre++;
      if (nib[15] !== 4'hD) bad_pre++;
      chk(bad_pre == 0, {"R2 preamble ", tag}, bad_pre, 0);
      // R3 low nibble first
      for (int i = 0; i < n; i++) begin
         if (nib[16 + 2 * i]     !== pbuf[i][3:0]) bad_dat++;
         if (nib[16 + 2 * i + 1] !== pbuf[i][7:4]) bad_dat++;
      end
      chk(bad_dat == 0, {"R3 payload ", tag}, bad_dat, 0);
      // R5 check sequence
      for (int k = 0; k < 8; k++) if (nib[16 + 2 * n + k] !== f[4 * k +: 4]) bad_fcs++;
      chk(bad_fcs == 0, {"R5 fcs ", tag}, bad_fcs, 0);
      // R6 completion pulse
      chk(n_done == 1 && n_abort == 0 && n_unr == 0, {"R6 done ", tag}, n_done, 1);
   endtask

   task automatic coll_test(input int at_nib, input int n, input string tag);
      int c0 = 0;
      int bad = 0;
      mon_clear();
      fill(n, 8'h3C, 5);
      fork
         send_frame(n, -1);
         begin
            wait (nib_cnt >= at_nib);
            @(negedge clk);
            c0 = nib_cnt;
            col_async = 1'b1;
            repeat (3) @(negedge clk);
            col_async = 1'b0;
         end
      join
      repeat (16) @(negedge clk);
      // R8 two normal nibbles, then eight jam nibbles, then enable low
      chk(nib_cnt == c0 + 10, {"R8 length ", tag}, nib_cnt, c0 + 10);
      for (int i = c0 + 2; i < c0 + 10; i++) if (nib[i] !== 4'h5) bad++;
      chk(bad == 0, {"R8 jam ", tag}, bad, 0);
      chk(n_abort == 1 && n_done == 0, {"R8 abort ", tag}, n_abort, 1);
      chk(mii_txen == 1'b0, {"R11 idle after drain ", tag}, mii_txen, 0);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(mii_txen == 0 && mii_txd == 0, "R1 outputs in reset", {mii_txen, mii_txd}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(s_ready == 0, "R1 ready after reset", s_ready, 0);
      chk({frame_done, frame_abort, tx_underrun, mii_txen} == 0, "R1 flags after reset",
          {frame_done, frame_abort, tx_underrun, mii_txen}, 0);

      // table of frames
      for (int v = 0; v < NV; v++) begin
         mon_clear();
         fill(VEC[v][0], VEC[v][1], VEC[v][2]);
         send_frame(VEC[v][0], -1);
         check_frame(VEC[v][0], $sformatf("vec%0d", v));
      end

      // R5 known check value over "123456789"
      mon_clear();
      fill(9, 8'h31, 1);
      send_frame(9, -1);
      repeat (16) @(negedge clk);
      begin
         logic [31:0] got;
         for (int k = 0; k < 8; k++) got[4 * k +: 4] = nib[34 + k];
         chk(got == 32'hCBF43926, "R5 check value", got, 32'hCBF43926);
      end

      // R8, R11 collision in preamble, then in payload
      coll_test(4, 30, "preamble");
      mon_clear();
      fill(20, 8'h77, 9);
      send_frame(20, -1);
      check_frame(20, "after abort R11");
      coll_test(40, 60, "payload");

      // R9 collision while idle
      mon_clear();
      col_async = 1'b1;
      repeat (6) @(negedge clk);
      col_async = 1'b0;
      repeat (6) @(negedge clk);
      chk(nib_cnt == 0 && n_abort == 0, "R9 idle collision", nib_cnt + n_abort, 0);

      // R10 underrun at byte 20, R11 drain
      mon_clear();
      fill(60, 8'h02, 11);
      send_frame(60, 20);
      repeat (16) @(negedge clk);
      chk(nib_cnt == 56, "R10 underrun length", nib_cnt, 56);
      chk(n_unr == 1 && n_done == 0, "R10 underrun pulse", n_unr, 1);
      mon_clear();
      fill(12, 8'hC3, 13);
      send_frame(12, -1);
      check_frame(12, "after underrun R11");

      finish_run();
   end

endmodule